// File: doc/BRIEF.md
# Cascaded Second-Order-Section Recursive Filter

This block is a fixed-coefficient recursive (IIR) filter of order `ORDER`, built as a serial chain of `(ORDER+1)/2` sections. Each input sample is first multiplied by a single gain constant. The product is requantized and registered. It then flows through the sections in turn. Every section except possibly the last is a full second-order section. When `ORDER` is odd, the last section is first order and keeps a single state element. Each section is a direct-form-II recursion: a feedback sum forms the state value, and a feed-forward sum over the state line forms the section output. Every section uses the same state width `SW`.

Coefficients are fixed-point parameters with `FRAC` fractional bits, supplied already quantized. They are packed into one vector of six-field records, one record per section. A registered rounding-and-saturation stage sits between neighbouring sections. The whole chain advances only on cycles where the clock enable is high. A synchronous active-high reset clears every register.

Top module: `iir_cascade`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared. After that edge `y_out` is 0, and the filter restarts from an all-zero state.
- R2: With `ce` high, a sample presented on `x_in` first reaches `y_out` after `NSEC+1` enabled edges (one gain register plus one register per section). Before that, an input history of zeros leaves `y_out` at 0.
- R3: The gain stage registers `rq(GAIN*x_in)`, where rq adds 2^(FRAC-1), shifts right arithmetically by FRAC and saturates to `DW` bits.
- R4: A second-order section with input u and states w1, w2 computes the state value w = satSW(rq'((u<<FRAC) - b1*w1 - b2*w2)) and the output y = satDW(rq'(a0*w + a1*w1 + a2*w2)). On each enabled edge it registers y and shifts w into w1 and w1 into w2.
- R5: When `ORDER` is odd, the last section has one state element, and its a2 and b2 fields have no effect on `y_out`.
- R6: Every requantization rounds half upward: a remainder of exactly one half moves the result toward plus infinity.
- R7: Each section output and the gain output saturate to [-2^(DW-1), 2^(DW-1)-1]. Each state value saturates to the `SW`-bit range.
- R8: While `ce` is low and `rst` is low, `y_out` and all filter state hold. Processing resumes from the held state.
- R9: Record k occupies `COEFS[k*6*CW +: 6*CW]` with fields a0, a1, a2, b0, b1, b2 from the least significant end, each `CW` bits signed. The b0 field is taken as 1.0 and is never multiplied, so its value has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, active high |
| x_in | input | DW | Input sample, signed two's complement |
| y_out | output | DW | Filtered output sample, signed, registered |

## Verification
The hardest state to reach from the ports is internal saturation deep in the chain. The last section's recursion has to overflow the output range while the earlier state lines stay inside their own width. The stimulus gets there with long input steps of both polarities, held until the high DC gain of the tail pushes it into clipping. Further stimulus covers pipeline fill after reset, ringing from an impulse, and alternating ±1 inputs that hit exact half-step rounding. It also drives a pseudo-random pattern with `ce` dropped at intervals. The default coefficients set nonzero values in the ignored b0 fields and in the unused fields of the odd tail, so any use of those fields shows up at `y_out`.

// File: rtl/iir_pkg.sv
`timescale 1ns/1ps
package iir_pkg;
  // field order inside one section record, least significant first
  typedef enum int {
    FLD_A0 = 0,
    FLD_A1 = 1,
    FLD_A2 = 2,
    FLD_B0 = 3,
    FLD_B1 = 4,
    FLD_B2 = 5
  } coef_field_e;

  localparam int REC_FIELDS = 6;

  function automatic int num_sections(input int order);
    return (order + 1) / 2;
  endfunction
endpackage

// File: rtl/iir_requant.sv
`timescale 1ns/1ps
// Round-half-up right shift followed by saturation to OW bits.
module iir_requant #(
  parameter int IW = 40,
  parameter int OW = 16,
  parameter int SH = 14
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam logic signed [IW:0] RND  = {{IW{1'b0}}, 1'b1} << (SH - 1);
  localparam logic signed [IW:0] MAXV = {{(IW - OW + 2){1'b0}}, {(OW - 1){1'b1}}};
  localparam logic signed [IW:0] MINV = ~MAXV;

  logic signed [IW:0] ext, shifted;

  always_comb begin
    ext     = {din[IW-1], din} + RND;
    shifted = ext >>> SH;
    if (shifted > MAXV)      dout = MAXV[OW-1:0];
    else if (shifted < MINV) dout = MINV[OW-1:0];
    else                     dout = shifted[OW-1:0];
  end
endmodule

// File: rtl/iir_section.sv
`timescale 1ns/1ps
// One direct-form-II section; first order when FIRST_ORDER is set.
module iir_section #(
  parameter int DW = 16,
  parameter int SW = 20,
  parameter int CW = 18,
  parameter int FRAC = 14,
  parameter bit FIRST_ORDER = 1'b0,
  parameter logic signed [CW-1:0] A0 = '0,
  parameter logic signed [CW-1:0] A1 = '0,
  parameter logic signed [CW-1:0] A2 = '0,
  parameter logic signed [CW-1:0] B1 = '0,
  parameter logic signed [CW-1:0] B2 = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y
);
  localparam int AW = CW + SW + 3;

  logic signed [SW-1:0] w, w1;
  logic signed [AW-1:0] fb, ff;
  logic signed [DW-1:0] yq;

  generate
    if (FIRST_ORDER) begin : g_first
      always_comb begin
        fb = (AW'(x) <<< FRAC) - AW'(B1) * AW'(w1);
        ff = AW'(A0) * AW'(w) + AW'(A1) * AW'(w1);
      end
    end else begin : g_second
      logic signed [SW-1:0] w2;
      always_ff @(posedge clk) begin
        if (rst)     w2 <= '0;
        else if (ce) w2 <= w1;
      end
      always_comb begin
        fb = (AW'(x) <<< FRAC) - AW'(B1) * AW'(w1) - AW'(B2) * AW'(w2);
        ff = AW'(A0) * AW'(w) + AW'(A1) * AW'(w1) + AW'(A2) * AW'(w2);
      end
    end
  endgenerate

  iir_requant #(.IW(AW), .OW(SW), .SH(FRAC)) u_state_q (.din(fb), .dout(w));
  iir_requant #(.IW(AW), .OW(DW), .SH(FRAC)) u_out_q   (.din(ff), .dout(yq));

  always_ff @(posedge clk) begin
    if (rst) begin
      w1 <= '0;
      y  <= '0;
    end else if (ce) begin
      w1 <= w;
      y  <= yq;
    end
  end
endmodule

// File: rtl/iir_cascade.sv
`timescale 1ns/1ps
module iir_cascade
  import iir_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int SW    = 20,
  parameter int FRAC  = 14,
  parameter int ORDER = 3,
  parameter logic signed [CW-1:0] GAIN = 18'sd8192,
  // records, section 0 at the low end; each record {b2,b1,b0,a2,a1,a0}
  parameter logic [REC_FIELDS*CW*((ORDER+1)/2)-1:0] COEFS = {
    18'sd5000, 18'(-12288), 18'sd777,   18'sd1234, 18'sd8192, 18'sd8192,
    18'sd8192, 18'(-16384), 18'sd16384, 18'sd4096, 18'sd8192, 18'sd4096
  }
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [DW-1:0] x_in,
  output logic signed [DW-1:0] y_out
);
  localparam int NSEC = num_sections(ORDER);
  localparam int RW   = REC_FIELDS * CW;
  localparam int GW   = CW + DW + 1;

  logic signed [GW-1:0] gain_prod;
  logic signed [DW-1:0] gain_c, gain_q;
  logic signed [DW-1:0] link [0:NSEC];

  assign gain_prod = GW'(x_in) * GW'(GAIN);

  iir_requant #(.IW(GW), .OW(DW), .SH(FRAC)) u_gain_q (.din(gain_prod), .dout(gain_c));

  always_ff @(posedge clk) begin
    if (rst)     gain_q <= '0;
    else if (ce) gain_q <= gain_c;
  end

  assign link[0] = gain_q;

  generate
    for (genvar k = 0; k < NSEC; k++) begin : g_sec
      iir_section #(
        .DW(DW), .SW(SW), .CW(CW), .FRAC(FRAC),
        .FIRST_ORDER((ORDER % 2 == 1) && (k == NSEC - 1)),
        .A0(COEFS[k*RW + FLD_A0*CW +: CW]),
        .A1(COEFS[k*RW + FLD_A1*CW +: CW]),
        .A2(COEFS[k*RW + FLD_A2*CW +: CW]),
        .B1(COEFS[k*RW + FLD_B1*CW +: CW]),
        .B2(COEFS[k*RW + FLD_B2*CW +: CW])
      ) u_sec (
        .clk(clk), .rst(rst), .ce(ce),
        .x(link[k]),
        .y(link[k+1])
      );
    end
  endgenerate

  assign y_out = link[NSEC];
endmodule

// File: rtl/iir_cascade_chk.sv
`timescale 1ns/1ps
module iir_cascade_chk #(
  parameter int DW = 16,
  parameter int NSEC = 2,
  parameter bit GAIN_NONNEG = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ce,
  input logic signed [DW-1:0] x_in,
  input logic signed [DW-1:0] y_out,
  input logic signed [DW-1:0] gain_q
);
  localparam int CNTW = $clog2(NSEC + 2) + 1;
  localparam logic [CNTW-1:0] FULL = CNTW'(NSEC + 1);

  // enabled edges since the first nonzero sample was accepted (0: none yet)
  logic [CNTW-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= '0;
    else if (ce) begin
      if (fill_cnt == '0) begin
        if (x_in != '0) fill_cnt <= CNTW'(1);
      end else if (fill_cnt < FULL) begin
        fill_cnt <= fill_cnt + CNTW'(1);
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (y_out == '0));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(y_out));

  a_r2_pipeline_fill: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt < FULL) |-> (y_out == '0));

  generate
    if (GAIN_NONNEG) begin : g_sign
      a_r3_gain_sign: assert property (@(posedge clk) disable iff (rst)
        (ce && !x_in[DW-1]) |=> !gain_q[DW-1]);
    end
  endgenerate
endmodule

bind iir_cascade iir_cascade_chk #(
  .DW(DW), .NSEC(NSEC), .GAIN_NONNEG(!GAIN[CW-1])
) u_chk (
  .clk(clk), .rst(rst), .ce(ce),
  .x_in(x_in), .y_out(y_out), .gain_q(gain_q)
);

// File: tb/iir_cascade_tb.sv
`timescale 1ns/1ps
module iir_cascade_tb;
  localparam int DW = 16;
  localparam int SW = 20;
  localparam int FRAC = 14;
  localparam int NSEC = 2;
  // coefficients restated for the model (b0 fields and tail a2/b2 ignored)
  localparam longint K = 8192;
  localparam longint S0A0 = 4096, S0A1 = 8192, S0A2 = 4096, S0B1 = -16384, S0B2 = 8192;
  localparam longint S1A0 = 8192, S1A1 = 8192, S1B1 = -12288;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic signed [DW-1:0] y_out;

  int n_checks = 0;
  int n_fail = 0;

  iir_cascade u_dut (.clk(clk), .rst(rst), .ce(ce), .x_in(x_in), .y_out(y_out));

  always #4 clk = ~clk;

  // model state
  longint m_g, m_w01, m_w02, m_y0, m_w11, m_y1;

  function automatic longint rq(input longint v, input int ow);
    longint t, hi, lo;
    t  = (v + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -(longint'(1) <<< (ow - 1));
    if (t > hi) return hi;
    if (t < lo) return lo;
    return t;
  endfunction

  task automatic model_reset();
    m_g = 0; m_w01 = 0; m_w02 = 0; m_y0 = 0; m_w11 = 0; m_y1 = 0;
  endtask

  task automatic model_step(input longint x);
    longint ng, w0, ny0, w1, ny1;
    ng  = rq(K * x, DW);
    w0  = rq((m_g <<< FRAC) - S0B1 * m_w01 - S0B2 * m_w02, SW);
    ny0 = rq(S0A0 * w0 + S0A1 * m_w01 + S0A2 * m_w02, DW);
    w1  = rq((m_y0 <<< FRAC) - S1B1 * m_w11, SW);
    ny1 = rq(S1A0 * w1 + S1A1 * m_w11, DW);
    m_w02 = m_w01; m_w01 = w0; m_y0 = ny0;
    m_w11 = w1; m_y1 = ny1; m_g = ng;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive, let the edge pass, compare away from the edge
  task automatic cyc(input longint x, input bit ce_v, input bit rst_v, input string req);
    x_in = DW'(x); ce = ce_v; rst = rst_v;
    @(posedge clk);
    if (rst_v) model_reset();
    else if (ce_v) model_step(x);
    @(negedge clk);
    check(longint'(y_out) == m_y1, req, longint'(y_out), m_y1);
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    longint held;
    int lfsr;
    model_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(0, 1'b1, 1'b1, "R1");
    check(y_out == '0, "R1", longint'(y_out), 0);

    // R2/R3: impulse of 8000 -> gain 4000 -> section0 1000 -> section1 500 on third edge
    cyc(8000, 1'b1, 1'b0, "R2");
    check(y_out == '0, "R2", longint'(y_out), 0);
    cyc(0, 1'b1, 1'b0, "R2");
    check(y_out == '0, "R2", longint'(y_out), 0);
    cyc(0, 1'b1, 1'b0, "R2");
    check(longint'(y_out) == 500, "R3", longint'(y_out), 500);
    for (int i = 0; i < 30; i++) cyc(0, 1'b1, 1'b0, "R4");

    // R8: enable low, input changes must not move anything
    cyc(1200, 1'b1, 1'b0, "R8");
    cyc(-900, 1'b1, 1'b0, "R8");
    held = longint'(y_out);
    for (int i = 0; i < 6; i++) begin
      cyc(31000 - i * 7000, 1'b0, 1'b0, "R8");
      check(longint'(y_out) == held, "R8", longint'(y_out), held);
    end
    for (int i = 0; i < 10; i++) cyc(0, 1'b1, 1'b0, "R8");

    // R6: exact half-step rounding with tiny inputs
    for (int i = 0; i < 24; i++) cyc((i % 2 == 0) ? 1 : -1, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 12; i++) cyc((i % 3) - 1 + 3 * (i % 2), 1'b1, 1'b0, "R6");

    // R7: long steps drive the odd tail into clipping
    for (int i = 0; i < 60; i++) cyc(20000, 1'b1, 1'b0, "R7");
    check(longint'(y_out) == 32767, "R7", longint'(y_out), 32767);
    for (int i = 0; i < 60; i++) cyc(-20000, 1'b1, 1'b0, "R7");
    check(longint'(y_out) == -32768, "R7", longint'(y_out), -32768);

    // R4, R5, R9: pseudo-random drive with enable gaps
    lfsr = 32'h1ACE;
    for (int i = 0; i < 150; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      cyc(longint'($signed(16'(lfsr))) >>> (i % 4), (i % 5) != 3, 1'b0, "R4,R5,R9");
    end

    // R1: reset in mid activity, then restart from zero state
    cyc(7777, 1'b1, 1'b1, "R1");
    check(y_out == '0, "R1", longint'(y_out), 0);
    cyc(8000, 1'b1, 1'b0, "R1");
    cyc(0, 1'b1, 1'b0, "R1");
    cyc(0, 1'b1, 1'b0, "R1");
    check(longint'(y_out) == 500, "R1", longint'(y_out), 500);
    for (int i = 0; i < 20; i++) cyc(0, 1'b1, 1'b0, "R5");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule